// File: doc/BRIEF.md
# Byte-Wide EEPROM Access and Burst Loader

This block gives a host three ways to use an external byte-wide EEPROM. The host can read one byte or write one byte, using a small register file that holds the control, address and data. The host can also start a burst. A burst walks the EEPROM, reads records made of a target address and a data byte, and writes each data byte into on-chip memory. Each on-chip target address is 24 bits wide. Its upper nine bits come from a base register that the host programs. Its lower fifteen bits come from the record.

The host sets request bits in the control register. The hardware clears each bit itself when its operation finishes, so the host polls the control register until it reads zero. A burst normally continues from the EEPROM address that follows the last access. The one exception is a burst that is the first access since reset, which starts at address zero. The EEPROM is reached through an abstract request/acknowledge byte port. The serial wire protocol sits outside this block.

Top module: `eeprom_burst_loader`

## Requirements
- R1: After reset, every host register reads 0, and neither `eeReq` nor `memWe` is asserted.
- R2: Writing 1 to control bit 1 (register select 0) starts a single read of the byte at the address register (select 1). The byte is loaded into the data register (select 2). Control bit 1 reads 1 until the acknowledge and 0 after it. The data is valid once the bit reads 0.
- R3: Writing 1 to control bit 0 writes the data register byte to the EEPROM at the address register. Control bit 0 reads 1 until the acknowledge and clears itself afterwards.
- R4: If bits 0 and 1 are written together, only the read is performed. Control bit 0 stays 0, and the EEPROM byte is not overwritten.
- R5: Writing 1 to control bit 2 starts a burst. Bit 2 reads 1 until the burst ends and then clears itself.
- R6: A burst that is the first EEPROM access since reset starts at EEPROM address 0. Any other burst starts at the address after the previous access, whether that access was a single access or the last byte read by a burst.
- R7: Each burst record is three EEPROM bytes: the address low byte, the address high byte, then the data byte. Each record produces one `memWe` pulse with `memAddr = {base[8:0], recordAddr[14:0]}` and the data byte. Record address bit 15 is ignored.
- R8: A record whose address bytes are both 0xFF ends the burst, and no memory write is made for it.
- R9: Control writes that arrive while any operation is in progress are ignored.
- R10: `eeReq` stays high, with `eeAddr`, `eeWr` and `eeWdata` stable, until `eeAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostSel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 base |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Read data of the selected register (combinational) |
| eeReq | output | 1 | EEPROM byte request |
| eeWr | output | 1 | 1 = write, 0 = read |
| eeAddr | output | 16 | EEPROM byte address |
| eeWdata | output | 8 | EEPROM write data |
| eeAck | input | 1 | One-cycle acknowledge of the request |
| eeRdata | input | 8 | Read data, valid with `eeAck` |
| memWe | output | 1 | On-chip memory byte write pulse |
| memAddr | output | 24 | On-chip memory byte address |
| memData | output | 8 | On-chip memory byte data |

## Verification
A wrong address pointer does not show at the start of a burst. It shows later, as a wrong `memAddr` or wrong data on the first `memWe` pulse. That pulse comes three EEPROM handshakes after the start. A terminator found at the wrong place shows up as a control bit 2 that never clears, or as extra write pulses.

A request bit that never clears leaves the control register nonzero forever, so polling exposes it within one handshake. A priority fault or a busy-time fault appears afterwards in the EEPROM contents or in the data register.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_BASE = 2'd3;

  localparam int CTL_WR    = 0;
  localparam int CTL_RD    = 1;
  localparam int CTL_BURST = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_SINGLE, S_BLO, S_BHI, S_BDAT, S_BWR
  } eebState_t;

  typedef struct packed {
    logic startBurst;
    logic singleDone;
    logic ldRdData;
    logic ldLo;
    logic ldHi;
    logic ldDat;
    logic incPtr;
  } eebStrobe_t;
endpackage

// File: rtl/eeb_ctrl.sv
module eeb_ctrl
  import eeb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrite,
  input  logic [2:0] ctlWdata,
  input  logic       eeAck,
  input  logic       recEnd,
  output eebStrobe_t stb,
  output logic       eeReq,
  output logic       eeWr,
  output logic       useBurstAddr,
  output logic       memWe,
  output logic [2:0] ctlBits
);
  eebState_t state, stateNext;
  logic opRead, opReadNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opRead <= 1'b0;
    end else begin
      state  <= stateNext;
      opRead <= opReadNext;
    end
  end

  always_comb begin
    stateNext  = state;
    opReadNext = opRead;
    stb        = '0;
    unique case (state)
      S_IDLE: begin
        if (ctlWrite) begin
          if (ctlWdata[CTL_RD]) begin
            stateNext  = S_SINGLE;
            opReadNext = 1'b1;
          end else if (ctlWdata[CTL_WR]) begin
            stateNext  = S_SINGLE;
            opReadNext = 1'b0;
          end else if (ctlWdata[CTL_BURST]) begin
            stateNext      = S_BLO;
            stb.startBurst = 1'b1;
          end
        end
      end
      S_SINGLE: if (eeAck) begin
        stb.singleDone = 1'b1;
        stb.ldRdData   = opRead;
        stateNext      = S_IDLE;
      end
      S_BLO: if (eeAck) begin
        stb.ldLo   = 1'b1;
        stb.incPtr = 1'b1;
        stateNext  = S_BHI;
      end
      S_BHI: if (eeAck) begin
        stb.incPtr = 1'b1;
        if (recEnd) stateNext = S_IDLE;
        else begin
          stb.ldHi  = 1'b1;
          stateNext = S_BDAT;
        end
      end
      S_BDAT: if (eeAck) begin
        stb.ldDat  = 1'b1;
        stb.incPtr = 1'b1;
        stateNext  = S_BWR;
      end
      S_BWR: stateNext = S_BLO;
      default: stateNext = S_IDLE;
    endcase
  end

  assign eeReq        = (state == S_SINGLE) || (state == S_BLO) ||
                        (state == S_BHI) || (state == S_BDAT);
  assign eeWr         = (state == S_SINGLE) && !opRead;
  assign useBurstAddr = (state != S_SINGLE);
  assign memWe        = (state == S_BWR);
  assign ctlBits[CTL_WR]    = (state == S_SINGLE) && !opRead;
  assign ctlBits[CTL_RD]    = (state == S_SINGLE) && opRead;
  assign ctlBits[CTL_BURST] = (state != S_IDLE) && (state != S_SINGLE);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rstN)
    eeReq && !eeAck |=> eeReq && $stable(eeWr));
  a_r2_rd_clears_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlBits[CTL_RD]) |-> $past(eeAck));
  a_r3_wr_clears_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlBits[CTL_WR]) |-> $past(eeAck));
  a_r5_burst_ends_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlBits[CTL_BURST]) |-> $past(eeAck) && $past(recEnd));
  a_r4_one_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctlBits));
  a_r7_write_after_data: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(eeAck) && !eeReq);
endmodule

// File: rtl/eeb_dpath.sv
module eeb_dpath
  import eeb_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [1:0]        hostSel,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  input  eebStrobe_t        stb,
  input  logic              useBurstAddr,
  input  logic [2:0]        ctlBits,
  input  logic [7:0]        eeRdata,
  output logic [EE_AW-1:0]  eeAddr,
  output logic [7:0]        eeWdata,
  output logic [MEM_AW-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              recEnd
);
  localparam int LOW_W = MEM_AW - BASE_W;

  logic [EE_AW-1:0]  addrReg, ptr;
  logic [7:0]        dataReg, loByte;
  logic [BASE_W-1:0] baseReg;
  logic              used;
  logic [15:0]       recWord;

  assign recWord = {eeRdata, loByte};
  assign recEnd  = (recWord == 16'hFFFF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      baseReg <= '0;
      ptr     <= '0;
      used    <= 1'b0;
      loByte  <= '0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      if (hostWe && hostSel == SEL_ADDR) addrReg <= hostWdata[EE_AW-1:0];
      if (hostWe && hostSel == SEL_BASE) baseReg <= hostWdata[BASE_W-1:0];
      if (stb.ldRdData) dataReg <= eeRdata;
      else if (hostWe && hostSel == SEL_DATA) dataReg <= hostWdata[7:0];

      if (stb.singleDone) begin
        ptr  <= addrReg + EE_AW'(1);
        used <= 1'b1;
      end else if (stb.startBurst) begin
        if (!used) ptr <= '0;
        used <= 1'b1;
      end else if (stb.incPtr) begin
        ptr <= ptr + EE_AW'(1);
      end

      if (stb.ldLo)  loByte  <= eeRdata;
      if (stb.ldHi)  memAddr <= {baseReg, recWord[LOW_W-1:0]};
      if (stb.ldDat) memData <= eeRdata;
    end
  end

  assign eeAddr  = useBurstAddr ? ptr : addrReg;
  assign eeWdata = dataReg;

  always_comb begin
    unique case (hostSel)
      SEL_CTRL: hostRdata = 32'(ctlBits);
      SEL_ADDR: hostRdata = 32'(addrReg);
      SEL_DATA: hostRdata = 32'(dataReg);
      default:  hostRdata = 32'(baseReg);
    endcase
  end

  a_r6_fresh_burst_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.startBurst && !used |=> eeAddr == '0);
  a_r7_base_in_upper_bits: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldHi |=> memAddr[MEM_AW-1 -: BASE_W] == $past(baseReg));
  a_r8_no_record_on_end: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldHi |-> !recEnd);
endmodule

// File: rtl/eeprom_burst_loader.sv
module eeprom_burst_loader
  import eeb_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [1:0]        hostSel,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              eeReq,
  output logic              eeWr,
  output logic [EE_AW-1:0]  eeAddr,
  output logic [7:0]        eeWdata,
  input  logic              eeAck,
  input  logic [7:0]        eeRdata,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [7:0]        memData
);
  eebStrobe_t stb;
  logic       useBurstAddr, recEnd;
  logic [2:0] ctlBits;
  logic       ctlWrite;

  assign ctlWrite = hostWe && (hostSel == SEL_CTRL);

  eeb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .ctlWdata(hostWdata[2:0]),
    .eeAck(eeAck), .recEnd(recEnd), .stb(stb), .eeReq(eeReq), .eeWr(eeWr),
    .useBurstAddr(useBurstAddr), .memWe(memWe), .ctlBits(ctlBits)
  );

  eeb_dpath #(.EE_AW(EE_AW), .MEM_AW(MEM_AW), .BASE_W(BASE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .stb(stb),
    .useBurstAddr(useBurstAddr), .ctlBits(ctlBits), .eeRdata(eeRdata),
    .eeAddr(eeAddr), .eeWdata(eeWdata), .memAddr(memAddr), .memData(memData),
    .recEnd(recEnd)
  );

  a_r9_busy_ignores_ctl: assert property (@(posedge clk) disable iff (!rstN)
    ctlBits != 3'b000 && !eeAck |=> $stable(ctlBits));
endmodule

// File: tb/sim_eeprom_burst_loader.sv
module sim_eeprom_burst_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        eeReq, eeWr, eeAck, memWe;
  logic [15:0] eeAddr;
  logic [7:0]  eeWdata, eeRdata, memData;
  logic [23:0] memAddr;

  logic [7:0]  eeMem [0:1023];
  logic        preWe = 1'b0;
  logic [9:0]  preAddr = '0;
  logic [7:0]  preData = '0;
  logic [23:0] logA [0:15];
  logic [7:0]  logD [0:15];
  int          logN = 0;
  int          nCmp = 0, nBad = 0;
  bit          finished = 1'b0;
  localparam logic [8:0] BASE = 9'h1AB;

  always #10 clk = ~clk;

  eeprom_burst_loader u0 (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .eeReq(eeReq), .eeWr(eeWr),
    .eeAddr(eeAddr), .eeWdata(eeWdata), .eeAck(eeAck), .eeRdata(eeRdata),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  // EEPROM model: one-cycle registered acknowledge
  always @(posedge clk) begin
    if (!rstN) begin
      eeAck   <= 1'b0;
      eeRdata <= '0;
    end else begin
      eeAck <= eeReq && !eeAck;
      if (eeReq && !eeAck) begin
        eeRdata <= eeMem[eeAddr[9:0]];
        if (eeWr) eeMem[eeAddr[9:0]] <= eeWdata;
      end
    end
    if (preWe) eeMem[preAddr] <= preData;
  end

  always @(posedge clk) begin
    if (memWe) begin
      logA[logN[3:0]] <= memAddr;
      logD[logN[3:0]] <= memData;
      logN <= logN + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    preAddr = a; preData = d; preWe = 1'b1;
    @(negedge clk);
    preWe = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    hostSel = sel; hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] d);
    hostSel = sel;
    #1;
    d = hostRdata;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      regRead(2'd0, v);
      if (v == 0) return;
    end
    check(req, v, 32'h0);
  endtask

  function automatic logic [23:0] tgt(input logic [15:0] a);
    return {BASE, a[14:0]};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      regRead(s[1:0], v);
      check("R1 register reset", v, 32'h0);
    end
    check("R1 eeReq idle", {31'b0, eeReq}, 32'h0);
    check("R1 memWe idle", {31'b0, memWe}, 32'h0);
  endtask

  task automatic t_first_burst;
    int n0;
    logic [31:0] v;
    preload(10'h000, 8'h23); preload(10'h001, 8'h81); preload(10'h002, 8'h5A);
    preload(10'h003, 8'h04); preload(10'h004, 8'h00); preload(10'h005, 8'hC3);
    preload(10'h006, 8'hFF); preload(10'h007, 8'hFF);
    regWrite(2'd3, {23'b0, BASE});
    n0 = logN;
    regWrite(2'd0, 32'h4);
    regRead(2'd0, v);
    check("R5 burst bit set", v, 32'h4);
    waitIdle("R5 burst bit clears");
    check("R6 R8 record count from addr 0", logN - n0, 2);
    check("R7 addr rec0 bit15 ignored", {8'b0, logA[n0[3:0]]}, {8'b0, tgt(16'h8123)});
    check("R7 data rec0", {24'b0, logD[n0[3:0]]}, 32'h5A);
    check("R7 addr rec1", {8'b0, logA[n0[3:0]+4'd1]}, {8'b0, tgt(16'h0004)});
    check("R7 data rec1", {24'b0, logD[n0[3:0]+4'd1]}, 32'hC3);
  endtask

  task automatic t_single_write;
    logic [31:0] v;
    preload(10'h005, 8'h00);
    regWrite(2'd1, 32'h5);
    regWrite(2'd2, 32'hA5);
    regWrite(2'd0, 32'h1);
    regRead(2'd0, v);
    check("R3 write bit set while busy", v, 32'h1);
    waitIdle("R3 write bit clears");
    check("R3 eeprom byte written", {24'b0, eeMem[5]}, 32'hA5);
  endtask

  task automatic t_single_read;
    logic [31:0] v;
    preload(10'h020, 8'h3C);
    regWrite(2'd1, 32'h20);
    regWrite(2'd0, 32'h2);
    regRead(2'd0, v);
    check("R2 read bit set while busy", v, 32'h2);
    waitIdle("R2 read bit clears");
    regRead(2'd2, v);
    check("R2 data loaded", v, 32'h3C);
  endtask

  task automatic t_burst_after_single;
    int n0;
    preload(10'h021, 8'h10); preload(10'h022, 8'h00); preload(10'h023, 8'hEE);
    preload(10'h024, 8'hFF); preload(10'h025, 8'hFF);
    n0 = logN;
    regWrite(2'd0, 32'h4);
    waitIdle("R5 burst clears");
    check("R6 continues after single", logN - n0, 1);
    check("R6 addr", {8'b0, logA[n0[3:0]]}, {8'b0, tgt(16'h0010)});
    check("R6 data", {24'b0, logD[n0[3:0]]}, 32'hEE);
  endtask

  task automatic t_burst_after_burst;
    int n0;
    preload(10'h026, 8'h05); preload(10'h027, 8'h80); preload(10'h028, 8'h42);
    preload(10'h029, 8'hFF); preload(10'h02A, 8'hFF);
    n0 = logN;
    regWrite(2'd0, 32'h4);
    waitIdle("R5 burst clears");
    check("R6 continues after burst", logN - n0, 1);
    check("R7 addr bit15 ignored", {8'b0, logA[n0[3:0]]}, {8'b0, tgt(16'h0005)});
    check("R7 data", {24'b0, logD[n0[3:0]]}, 32'h42);
  endtask

  task automatic t_both_bits;
    logic [31:0] v;
    preload(10'h030, 8'h77);
    regWrite(2'd1, 32'h30);
    regWrite(2'd2, 32'h11);
    regWrite(2'd0, 32'h3);
    regRead(2'd0, v);
    check("R4 only read bit set", v, 32'h2);
    waitIdle("R4 bits clear");
    regRead(2'd2, v);
    check("R4 read data", v, 32'h77);
    check("R4 eeprom not written", {24'b0, eeMem[10'h030]}, 32'h77);
  endtask

  task automatic t_ignore_busy;
    int n0;
    logic [31:0] v;
    preload(10'h031, 8'hFF); preload(10'h032, 8'hFF);
    preload(10'h040, 8'h5C);
    regWrite(2'd1, 32'h40);
    n0 = logN;
    regWrite(2'd0, 32'h4);
    regWrite(2'd0, 32'h2);
    waitIdle("R9 returns idle");
    repeat (6) @(negedge clk);
    regRead(2'd0, v);
    check("R9 no read started", v, 32'h0);
    regRead(2'd2, v);
    check("R9 data register untouched", v, 32'h77);
    check("R8 terminator gives no write", logN - n0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_first_burst();
    t_single_write();
    t_single_read();
    t_burst_after_single();
    t_burst_after_burst();
    t_both_bits();
    t_ignore_busy();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule